// File: doc/BRIEF.md
# Parallel Bus Master Controller

This block is the host side of an 8-bit external parallel bus. A CPU-side request (read or write, 16-bit address, 8-bit write data) enters on a valid/ready handshake. The block turns it into one external bus cycle: zero, one or two address phases, then a data phase of fixed length. When the cycle ends, a one-clock response pulse returns the read byte.

A 16-bit control word, written through a plain write port and readable at all times, configures the bus. It holds the master enable and the address/data multiplexing mode. It also chooses whether the chip-select pin is a select or carries address bit 14, sets the polarity of each strobe, and says which strobe ports are driven at all.

Handshake rules: a request transfers on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` is high only when the master is enabled and no cycle is in progress. A source that sees `req_ready` low must hold its request. The response has no back-pressure: `rsp_valid` is a single-clock pulse that the consumer must take when it appears.

Top module: `pmp_master`

## Requirements
- R1: The control word resets to 0. Writing it stores every bit except bits 14 and 4, which always read back as 0. Bit 13 is a plain stored flag.
- R2: When control bit 15 (enable) is 0, `req_ready` stays 0 and no bus cycle starts. Every strobe sits at its inactive level, which is the inverse of its polarity bit.
- R3: In mode 2 (control bits 12:11 = 10), an accepted request first runs one clock with the low address byte on `bus_dout` and `ale_lo` active. It then runs one clock with the high address byte on `bus_dout` and `ale_hi` active. The data phase follows. `bus_addr` is 0 in this mode.
- R4: In mode 1 (bits 12:11 = 01), only the low-byte address phase precedes the data phase. During the cycle `bus_addr` carries the request address with bits 7:0 forced to 0.
- R5: In mode 0 (00), and in the reserved mode 3 (11), the cycle goes straight to the data phase, with the full address on `bus_addr` for the whole cycle. `bus_doe` is 1 only during the data phase of a write. `bus_dout` is 0 whenever it is not driven.
- R6: The data phase keeps the read or write strobe active for exactly 2 clocks. `bus_din` is sampled at the end of the second clock. `rsp_valid` pulses for one clock in the following cycle, and for a read `rsp_rdata` then holds the sampled byte.
- R7: While a cycle is in progress, `busy` is 1 and `req_ready` is 0, so a request offered then is not accepted.
- R8: With control bit 7 = 1 (function 10, or the reserved 11), `cs1` is a chip select. It is active from the first phase of a cycle through its last data clock, at the level given by bit 3 (1 = high). Otherwise it is at the inverse level.
- R9: With control bit 7 = 0, `cs1` carries bit 14 of the request address during a cycle and 0 when idle. Bit 3 has no effect.
- R10: Control bit 5 sets the active level of both `ale_lo` and `ale_hi` (1 = high). Outside their own phase they sit at the inverse level, and the two are never active together.
- R11: Bits 10, 9 and 8 enable the byte-enable, write-strobe and read-strobe ports. Bits 2, 1 and 0 give their respective active levels (1 = high). A disabled port stays at its inactive level.
- R12: The byte enable `be` is active for both data-phase clocks of a read or a write. The read strobe is active only for reads and the write strobe only for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write value |
| cfg_rdata | output | 16 | Control word read value |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-clock cycle-done pulse |
| rsp_rdata | output | 8 | Read data, valid with `rsp_valid` on reads |
| busy | output | 1 | Bus cycle in progress |
| bus_dout | output | 8 | Data/address pins out |
| bus_doe | output | 1 | Drive enable for `bus_dout` |
| bus_din | input | 8 | Data pins in |
| bus_addr | output | 16 | Separate address pins |
| ale_lo | output | 1 | Low address latch strobe |
| ale_hi | output | 1 | High address latch strobe |
| cs1 | output | 1 | Chip select or address bit 14 |
| rd_strb | output | 1 | Read strobe |
| wr_strb | output | 1 | Write strobe |
| be | output | 1 | Byte enable |

## Verification
The bench compares every pin on every clock of a cycle against a phase model. This catches a design that skips or repeats an address phase, puts the bytes out in the wrong order, or treats reserved mode 3 as anything but mode 0. Directed cases cover several failures: inverted or ignored polarities (a strobe idling at the wrong level), a disabled port that still toggles, a chip-select pin that keeps its polarity while it carries address bit 14, and a one- or three-clock data phase. It also offers requests while the block is busy and while the enable is clear. A design that accepted such a request would run an extra cycle that the pin comparison shows.

// File: rtl/pmp_pkg.sv
package pmp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ALO  = 2'd1,
    ST_AHI  = 2'd2,
    ST_DATA = 2'd3
  } pmp_state_e;

  localparam logic [15:0] CFG_MASK = 16'hBFEF;

  localparam int B_EN    = 15;
  localparam int B_MUXHI = 12;
  localparam int B_MUXLO = 11;
  localparam int B_CSSEL = 7;
  localparam int B_ALP   = 5;
  localparam int B_CSP   = 3;
  localparam int B_PORT0 = 8;
  localparam int B_POL0  = 0;

  localparam logic [1:0] MUX_SPLIT = 2'b00;
  localparam logic [1:0] MUX_LOW   = 2'b01;
  localparam logic [1:0] MUX_FULL  = 2'b10;
endpackage

// File: rtl/pmp_cfg_reg.sv
module pmp_cfg_reg #(
  parameter int          W    = 16,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata & MASK;
  end
endmodule

// File: rtl/pmp_seq.sv
module pmp_seq
  import pmp_pkg::*;
#(
  parameter int DW        = 8,
  parameter int DATA_CLKS = 2,
  localparam int AW       = 2 * DW,
  localparam int CW       = (DATA_CLKS > 1) ? $clog2(DATA_CLKS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [1:0]    mode,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] bus_din,
  output pmp_state_e    state,
  output logic [1:0]    cur_mode,
  output logic          cur_write,
  output logic [AW-1:0] cur_addr,
  output logic [DW-1:0] cur_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  localparam logic [CW-1:0] LAST = CW'(DATA_CLKS - 1);
  logic [CW-1:0] cnt;

  assign req_ready = enable && (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      cur_mode  <= '0;
      cur_write <= 1'b0;
      cur_addr  <= '0;
      cur_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid && req_ready) begin
          cur_mode  <= mode;
          cur_write <= req_write;
          cur_addr  <= req_addr;
          cur_wdata <= req_wdata;
          cnt       <= '0;
          state     <= (mode == MUX_FULL || mode == MUX_LOW) ? ST_ALO : ST_DATA;
        end
        ST_ALO:  state <= (cur_mode == MUX_FULL) ? ST_AHI : ST_DATA;
        ST_AHI:  state <= ST_DATA;
        ST_DATA: begin
          if (cnt == LAST) begin
            state     <= ST_IDLE;
            rsp_valid <= 1'b1;
            if (!cur_write) rsp_rdata <= bus_din;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pmp_pins.sv
module pmp_pins
  import pmp_pkg::*;
#(
  parameter int DW   = 8,
  localparam int AW  = 2 * DW,
  localparam int NPT = 3
) (
  input  logic [15:0]   cfg,
  input  pmp_state_e    state,
  input  logic [1:0]    cur_mode,
  input  logic          cur_write,
  input  logic [AW-1:0] cur_addr,
  input  logic [DW-1:0] cur_wdata,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  output logic [AW-1:0] bus_addr,
  output logic          ale_lo,
  output logic          ale_hi,
  output logic          cs1,
  output logic          rd_strb,
  output logic          wr_strb,
  output logic          be
);
  logic active, data_ph;
  logic [NPT-1:0] want, strb;

  assign active  = (state != ST_IDLE);
  assign data_ph = (state == ST_DATA);

  always_comb begin
    bus_doe  = 1'b0;
    bus_dout = '0;
    case (state)
      ST_ALO: begin bus_doe = 1'b1; bus_dout = cur_addr[DW-1:0];  end
      ST_AHI: begin bus_doe = 1'b1; bus_dout = cur_addr[AW-1:DW]; end
      ST_DATA: if (cur_write) begin bus_doe = 1'b1; bus_dout = cur_wdata; end
      default: ;
    endcase
  end

  always_comb begin
    bus_addr = '0;
    if (active) begin
      case (cur_mode)
        MUX_FULL: bus_addr = '0;
        MUX_LOW:  bus_addr = {cur_addr[AW-1:DW], {DW{1'b0}}};
        default:  bus_addr = cur_addr;
      endcase
    end
  end

  assign ale_lo = (state == ST_ALO) ? cfg[B_ALP] : ~cfg[B_ALP];
  assign ale_hi = (state == ST_AHI) ? cfg[B_ALP] : ~cfg[B_ALP];

  assign cs1 = cfg[B_CSSEL] ? (active ? cfg[B_CSP] : ~cfg[B_CSP])
                            : (active & cur_addr[14]);

  // port order: 0 = read strobe, 1 = write strobe, 2 = byte enable
  assign want = {data_ph, data_ph & cur_write, data_ph & ~cur_write};

  for (genvar g = 0; g < NPT; g++) begin : g_port
    assign strb[g] = (cfg[B_PORT0+g] && want[g]) ? cfg[B_POL0+g] : ~cfg[B_POL0+g];
  end

  assign rd_strb = strb[0];
  assign wr_strb = strb[1];
  assign be      = strb[2];
endmodule

// File: rtl/pmp_master.sv
module pmp_master
  import pmp_pkg::*;
#(
  parameter int DW        = 8,
  parameter int DATA_CLKS = 2,
  localparam int AW       = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [15:0]   cfg_wdata,
  output logic [15:0]   cfg_rdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          busy,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  input  logic [DW-1:0] bus_din,
  output logic [AW-1:0] bus_addr,
  output logic          ale_lo,
  output logic          ale_hi,
  output logic          cs1,
  output logic          rd_strb,
  output logic          wr_strb,
  output logic          be
);
  pmp_state_e    state;
  logic [1:0]    cur_mode;
  logic          cur_write;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] cur_wdata;

  pmp_cfg_reg #(.W(16), .MASK(CFG_MASK)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .q(cfg_rdata)
  );

  pmp_seq #(.DW(DW), .DATA_CLKS(DATA_CLKS)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .enable(cfg_rdata[B_EN]), .mode(cfg_rdata[B_MUXHI:B_MUXLO]),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .bus_din(bus_din),
    .state(state), .cur_mode(cur_mode), .cur_write(cur_write),
    .cur_addr(cur_addr), .cur_wdata(cur_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  assign busy = (state != ST_IDLE);

  pmp_pins #(.DW(DW)) u_pins (
    .cfg(cfg_rdata), .state(state), .cur_mode(cur_mode), .cur_write(cur_write),
    .cur_addr(cur_addr), .cur_wdata(cur_wdata),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_addr(bus_addr),
    .ale_lo(ale_lo), .ale_hi(ale_hi), .cs1(cs1),
    .rd_strb(rd_strb), .wr_strb(wr_strb), .be(be)
  );
endmodule

// File: rtl/pmp_master_sva.sv
module pmp_master_sva (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cfg_rdata,
  input logic        req_ready,
  input logic        busy,
  input logic        rsp_valid,
  input logic        ale_lo,
  input logic        ale_hi,
  input logic        rd_strb
);
  logic rd_act;
  assign rd_act = cfg_rdata[8] && (rd_strb == cfg_rdata[0]);

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[14] == 1'b0) && (cfg_rdata[4] == 1'b0)); // R1
  AST_NO_ACCEPT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[15] |-> !req_ready); // R2
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R6
  AST_RD_TWO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_act) |=> rd_act); // R6
  AST_ALE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !((ale_lo == cfg_rdata[5]) && (ale_hi == cfg_rdata[5]))); // R10
endmodule

bind pmp_master pmp_master_sva u_sva (
  .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata), .req_ready(req_ready),
  .busy(busy), .rsp_valid(rsp_valid), .ale_lo(ale_lo), .ale_hi(ale_hi),
  .rd_strb(rd_strb)
);

// File: tb/pmp_master_test.sv
`timescale 1ns/1ps
module pmp_master_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0, bus_din = '0;
  logic req_ready, rsp_valid, busy, bus_doe, ale_lo, ale_hi, cs1, rd_strb, wr_strb, be;
  logic [7:0] rsp_rdata, bus_dout;
  logic [15:0] bus_addr;

  int n_chk = 0, n_bad = 0;
  logic [15:0] mcfg = '0;

  localparam int PH_IDLE = 0, PH_ALO = 1, PH_AHI = 2, PH_DAT = 3;

  always #2 clk = ~clk;

  pmp_master uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .busy(busy), .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
    .bus_addr(bus_addr), .ale_lo(ale_lo), .ale_hi(ale_hi), .cs1(cs1),
    .rd_strb(rd_strb), .wr_strb(wr_strb), .be(be)
  );

  function automatic logic [30:0] pins_now();
    return {bus_dout, bus_doe, bus_addr, ale_lo, ale_hi, cs1, rd_strb, wr_strb, be};
  endfunction

  function automatic logic [30:0] exp_pins(int ph, logic [15:0] c, logic w,
                                           logic [15:0] a, logic [7:0] d);
    logic act, dat, doe, al, ah, cs, rd, wr, b;
    logic [7:0] dout;
    logic [15:0] ao;
    act = (ph != PH_IDLE);
    dat = (ph == PH_DAT);
    doe = (ph == PH_ALO) || (ph == PH_AHI) || (dat && w);
    dout = (ph == PH_ALO) ? a[7:0] : (ph == PH_AHI) ? a[15:8] : (dat && w) ? d : 8'h00;
    if (!act) ao = '0;
    else if (c[12:11] == 2'b10) ao = '0;
    else if (c[12:11] == 2'b01) ao = {a[15:8], 8'h00};
    else ao = a;
    al = (ph == PH_ALO) ? c[5] : ~c[5];
    ah = (ph == PH_AHI) ? c[5] : ~c[5];
    cs = c[7] ? (act ? c[3] : ~c[3]) : (act && a[14]);
    rd = (c[8] && dat && !w) ? c[0] : ~c[0];
    wr = (c[9] && dat && w) ? c[1] : ~c[1];
    b  = (c[10] && dat) ? c[2] : ~c[2];
    return {dout, doe, ao, al, ah, cs, rd, wr, b};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic set_cfg(logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    mcfg = v & 16'hBFEF;
    chk("R1 cfg readback", {16'h0, cfg_rdata}, {16'h0, mcfg});
  endtask

  task automatic do_req(string tag, logic w, logic [15:0] a, logic [7:0] d,
                        logic [7:0] din, bit poke);
    int ph[4];
    int n;
    case (mcfg[12:11])
      2'b10: begin ph = '{PH_ALO, PH_AHI, PH_DAT, PH_DAT}; n = 4; end
      2'b01: begin ph = '{PH_ALO, PH_DAT, PH_DAT, PH_IDLE}; n = 3; end
      default: begin ph = '{PH_DAT, PH_DAT, PH_IDLE, PH_IDLE}; n = 2; end
    endcase
    @(negedge clk);
    chk("R7 ready when idle", {31'h0, req_ready}, 32'h1);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; bus_din = din;
    @(posedge clk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (poke && i < n - 1) begin
        req_addr = ~a; req_write = ~w;
        chk("R7 ready low while busy", {30'h0, busy, req_ready}, 32'h2);
      end else begin
        req_valid = 1'b0;
      end
      chk(tag, {1'b0, pins_now()}, {1'b0, exp_pins(ph[i], mcfg, w, a, d)});
      chk("R6 no early done", {31'h0, rsp_valid}, 32'h0);
    end
    @(negedge clk);
    chk("R6 done pulse", {31'h0, rsp_valid}, 32'h1);
    if (!w) chk("R6 read data", {24'h0, rsp_rdata}, {24'h0, din});
    chk("R7 idle after cycle", {1'b0, pins_now()}, {1'b0, exp_pins(PH_IDLE, mcfg, w, a, d)});
    @(negedge clk);
    chk("R6 pulse one clock", {31'h0, rsp_valid}, 32'h0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [15:0] c;
    string tg;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset cfg", {16'h0, cfg_rdata}, 32'h0);
    chk("R2 reset pins", {1'b0, pins_now()}, {1'b0, exp_pins(PH_IDLE, 16'h0, 1'b0, 16'h0, 8'h0)});

    set_cfg(16'hFFFF);
    chk("R1 bits 14 and 4 zero", {16'h0, cfg_rdata}, 32'h0000BFEF);

    // disabled master: offered request must never start a cycle
    set_cfg(16'h7F2F);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h1234; req_wdata = 8'h55;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R2 not ready when off", {30'h0, busy, req_ready}, 32'h0);
      chk("R2 pins inactive when off", {1'b0, pins_now()},
          {1'b0, exp_pins(PH_IDLE, mcfg, 1'b1, 16'h1234, 8'h55)});
    end
    req_valid = 1'b0;

    set_cfg(16'h9780);
    do_req("R3 full mux read", 1'b0, 16'hA5C3, 8'h00, 8'h3C, 1'b0);
    do_req("R3 full mux write", 1'b1, 16'h4B21, 8'h9E, 8'h00, 1'b0);
    set_cfg(16'h8F80);
    do_req("R4 low mux write", 1'b1, 16'h07F1, 8'h11, 8'h00, 1'b0);
    set_cfg(16'h8780);
    do_req("R5 split read", 1'b0, 16'hFFFF, 8'h00, 8'hA7, 1'b0);
    set_cfg(16'h9F80);
    do_req("R5 reserved mode", 1'b1, 16'h0102, 8'h77, 8'h00, 1'b0);
    set_cfg(16'h9788);
    do_req("R7 busy rejects", 1'b0, 16'h8001, 8'h00, 8'h5A, 1'b1);
    set_cfg(16'h8788);
    do_req("R8 cs high active", 1'b1, 16'h0000, 8'hC0, 8'h00, 1'b0);
    set_cfg(16'h8708);
    do_req("R9 cs as a14 set", 1'b0, 16'h4000, 8'h00, 8'h01, 1'b0);
    do_req("R9 cs as a14 clear", 1'b1, 16'hBFFF, 8'h02, 8'h00, 1'b0);
    set_cfg(16'h97A0);
    do_req("R10 ale active high", 1'b0, 16'h1357, 8'h00, 8'hE1, 1'b0);
    set_cfg(16'h8287);
    do_req("R11 only wr port", 1'b1, 16'h2468, 8'h4D, 8'h00, 1'b0);
    do_req("R11 rd port off", 1'b0, 16'h2469, 8'h00, 8'h4E, 1'b0);
    set_cfg(16'h8480);
    do_req("R12 be on read", 1'b0, 16'h0F0F, 8'h00, 8'h99, 1'b0);

    for (int k = 0; k < 60; k++) begin
      c = 16'($urandom()) | 16'h8000;
      set_cfg(c);
      case (mcfg[12:11])
        2'b10:   tg = "R3 random";
        2'b01:   tg = "R4 random";
        default: tg = "R5 random";
      endcase
      do_req(tg, 1'($urandom()), 16'($urandom()), 8'($urandom()), 8'($urandom()),
             1'($urandom_range(0, 3) == 0));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule